// File: doc/BRIEF.md
# Masked Blend SAD Engine

This block measures how far a source block is from a blended prediction. The prediction is not supplied directly. For every pixel, two candidate predictions are mixed with a per-pixel alpha weight between 0 and 64, with rounding, and the result is compared with the source pixel. The absolute differences are summed over the whole block. Motion search uses this figure to score masked compound predictions.

A single start pulse selects the block width (4 to 128 pixels), the number of rows, and which candidate takes the mask weight. Pixel data then arrives on a valid/ready stream. Each beat carries eight lanes, and each lane holds a source, a reference, a second-prediction and a mask sample. A row of 4 pixels fits in one beat, with the upper lanes unused. A wider row takes width/8 beats. When the last beat of the last row has been taken, the block pulses done and holds the final sum until the next start. The sample width is a parameter, so the same block serves 8-bit and high-bit-depth video.

Top module: `blend_sad_engine`

## Requirements
- R1: With the invert flag clear, each predicted pixel is (m·ref + (64−m)·sec + 32) >> 6. An exact half rounds up and anything below a half rounds down.
- R2: With the invert flag set, the mask weight m applies to the second prediction and 64−m applies to the reference.
- R3: sadTotal equals the sum of |predicted − source| over every active pixel of every row, kept in a 32-bit accumulator.
- R4: After reset, busy, donePulse and sadTotal are all 0. A start pulse while idle latches the width code, height and invert flag, clears sadTotal to 0 and raises busy on the next cycle.
- R5: A start pulse while busy has no effect: the settings and the running sum are kept.
- R6: Width code 0 (4 pixels) uses lanes 0..3 only. Whatever is driven on lanes 4..7 leaves the sum unchanged. Lane k occupies bits [k·W +: W] of each sample bus, and the mask bus uses 8 bits per lane.
- R7: Width codes 0..5 select widths 4, 8, 16, 32, 64 and 128. A block takes height·max(1, width/8) beats. On the cycle after the last beat is taken, donePulse is 1 and busy is 0.
- R8: beatReady equals busy. A beat is taken only on a cycle where beatValid and beatReady are both high, and cycles without beatValid do not change the sum.
- R9: donePulse lasts exactly one cycle. sadTotal keeps its final value until the next accepted start.
- R10: A mask of 0 gives exactly the unweighted candidate as the prediction, and a mask of 64 gives exactly the weighted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a block when idle |
| widthCode | input | 3 | Block width: 0=4, 1=8, 2=16, 3=32, 4=64, 5=128 |
| heightRows | input | HEIGHT_W | Number of rows, at least 1 |
| invertSel | input | 1 | 1 applies the mask weight to the second prediction |
| beatValid | input | 1 | A beat of pixel data is present |
| srcBeat | input | 8·SAMPLE_W | Source samples, lane k at [k·SAMPLE_W +: SAMPLE_W] |
| refBeat | input | 8·SAMPLE_W | Reference samples |
| secBeat | input | 8·SAMPLE_W | Second-prediction samples |
| maskBeat | input | 64 | Mask values 0..64, 8 bits per lane |
| beatReady | output | 1 | A beat will be taken |
| busy | output | 1 | A block is in progress |
| donePulse | output | 1 | One-cycle pulse after the last beat |
| sadTotal | output | ACC_W | Running sum, final once done |

## Verification
The first tests use constant blocks. Masks of 31 and 32 on a one-step difference show whether rounding is half-up or truncating. Masks of 0 and 64, run once with each invert setting, show which candidate carries the weight. The 4-wide blocks always drive large values on the unused lanes, so a lane-enable error changes the sum. Random data, with random masks and gaps in the valid stream, is run at several widths up to 128x128 and compared every cycle against a behavioural model. A start pulse issued partway through a block must change neither the beat count nor the sum.

// File: rtl/blend_sad_pkg.sv
package blend_sad_pkg;
  localparam int LANE_COUNT = 8;
  localparam int BLEND_BITS = 6;
  localparam int MASK_W     = 8;
  localparam int WCODE_W    = 3;
  localparam int MAX_WIDTH  = 128;
  localparam int MIN_WIDTH  = 4;

  typedef struct packed {
    logic                  clearAcc;
    logic                  addBeat;
    logic                  swapSel;
    logic [LANE_COUNT-1:0] laneEn;
  } dpCtrl_t;
endpackage

// File: rtl/blend_sad_ctrl.sv
module blend_sad_ctrl
  import blend_sad_pkg::*;
#(
  parameter int HEIGHT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [WCODE_W-1:0] widthCode,
  input  logic [HEIGHT_W-1:0] heightRows,
  input  logic               invertSel,
  input  logic               beatValid,
  output logic               beatReady,
  output logic               busy,
  output logic               donePulse,
  output dpCtrl_t            strobes
);
  localparam int BEAT_W = $clog2(MAX_WIDTH / LANE_COUNT) + 1;
  localparam int PIX_W  = $clog2(MAX_WIDTH) + 2;

  logic               busyQ, doneQ, invQ;
  logic [WCODE_W-1:0] wcQ;
  logic [HEIGHT_W-1:0] heightQ, rowIdx;
  logic [BEAT_W-1:0]  beatIdx, beatsM1;
  logic               fire, lastBeat, lastRow, accept;
  logic [LANE_COUNT-1:0] laneEn;

  assign beatsM1  = (wcQ <= WCODE_W'(1)) ? '0
                  : ((BEAT_W'(1) << (wcQ - WCODE_W'(1))) - BEAT_W'(1));
  assign fire     = busyQ & beatValid;
  assign accept   = ~busyQ & startPulse;
  assign lastBeat = (beatIdx == beatsM1);
  assign lastRow  = (rowIdx == heightQ - HEIGHT_W'(1));

  for (genvar k = 0; k < LANE_COUNT; k++) begin : g_laneEn
    assign laneEn[k] = (PIX_W'(k) < (PIX_W'(MIN_WIDTH) << wcQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      invQ    <= 1'b0;
      wcQ     <= '0;
      heightQ <= '0;
      rowIdx  <= '0;
      beatIdx <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        busyQ   <= 1'b1;
        wcQ     <= widthCode;
        heightQ <= heightRows;
        invQ    <= invertSel;
        rowIdx  <= '0;
        beatIdx <= '0;
      end else if (fire) begin
        if (lastBeat) begin
          beatIdx <= '0;
          if (lastRow) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            rowIdx <= rowIdx + HEIGHT_W'(1);
          end
        end else begin
          beatIdx <= beatIdx + BEAT_W'(1);
        end
      end
    end
  end

  assign beatReady        = busyQ;
  assign busy             = busyQ;
  assign donePulse        = doneQ;
  assign strobes.clearAcc = accept;
  assign strobes.addBeat  = fire;
  assign strobes.swapSel  = invQ;
  assign strobes.laneEn   = laneEn;
endmodule

// File: rtl/blend_sad_dp.sv
module blend_sad_dp
  import blend_sad_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpCtrl_t                        strobes,
  input  logic [LANE_COUNT*SAMPLE_W-1:0] srcBeat,
  input  logic [LANE_COUNT*SAMPLE_W-1:0] refBeat,
  input  logic [LANE_COUNT*SAMPLE_W-1:0] secBeat,
  input  logic [LANE_COUNT*MASK_W-1:0]   maskBeat,
  output logic [ACC_W-1:0]               sadAcc
);
  localparam int FULL_WT = 1 << BLEND_BITS;
  localparam int HALF_WT = FULL_WT >> 1;
  localparam int PROD_W  = SAMPLE_W + MASK_W + 3;
  localparam logic [PROD_W-1:0] MAXV = PROD_W'((1 << SAMPLE_W) - 1);

  logic [SAMPLE_W-1:0] laneDiff [LANE_COUNT];
  logic [ACC_W-1:0]    beatSum;

  for (genvar k = 0; k < LANE_COUNT; k++) begin : g_lane
    logic [SAMPLE_W-1:0] s, a, b, pred;
    logic [MASK_W-1:0]   m;
    logic [MASK_W:0]     mc;
    logic [PROD_W-1:0]   mix, scaled;

    assign s  = srcBeat[k*SAMPLE_W +: SAMPLE_W];
    assign m  = maskBeat[k*MASK_W +: MASK_W];
    assign a  = strobes.swapSel ? secBeat[k*SAMPLE_W +: SAMPLE_W]
                                : refBeat[k*SAMPLE_W +: SAMPLE_W];
    assign b  = strobes.swapSel ? refBeat[k*SAMPLE_W +: SAMPLE_W]
                                : secBeat[k*SAMPLE_W +: SAMPLE_W];
    assign mc = (MASK_W+1)'(FULL_WT) - {1'b0, m};
    assign mix = PROD_W'(m) * PROD_W'(a) + PROD_W'(mc) * PROD_W'(b)
               + PROD_W'(HALF_WT);
    assign scaled = mix >> BLEND_BITS;
    assign pred   = (scaled > MAXV) ? MAXV[SAMPLE_W-1:0] : scaled[SAMPLE_W-1:0];
    assign laneDiff[k] = !strobes.laneEn[k] ? '0
                       : (pred >= s) ? (pred - s) : (s - pred);
  end

  always_comb begin
    beatSum = '0;
    for (int k = 0; k < LANE_COUNT; k++) beatSum = beatSum + ACC_W'(laneDiff[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 sadAcc <= '0;
    else if (strobes.clearAcc) sadAcc <= '0;
    else if (strobes.addBeat)  sadAcc <= sadAcc + beatSum;
  end
endmodule

// File: rtl/blend_sad_engine.sv
module blend_sad_engine
  import blend_sad_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int HEIGHT_W = 8,
  parameter int ACC_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startPulse,
  input  logic [2:0]                     widthCode,
  input  logic [HEIGHT_W-1:0]            heightRows,
  input  logic                           invertSel,
  input  logic                           beatValid,
  input  logic [LANE_COUNT*SAMPLE_W-1:0] srcBeat,
  input  logic [LANE_COUNT*SAMPLE_W-1:0] refBeat,
  input  logic [LANE_COUNT*SAMPLE_W-1:0] secBeat,
  input  logic [LANE_COUNT*MASK_W-1:0]   maskBeat,
  output logic                           beatReady,
  output logic                           busy,
  output logic                           donePulse,
  output logic [ACC_W-1:0]               sadTotal
);
  dpCtrl_t strobes;

  blend_sad_ctrl #(.HEIGHT_W(HEIGHT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .widthCode(widthCode),
    .heightRows(heightRows), .invertSel(invertSel), .beatValid(beatValid),
    .beatReady(beatReady), .busy(busy), .donePulse(donePulse),
    .strobes(strobes)
  );

  blend_sad_dp #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcBeat(srcBeat),
    .refBeat(refBeat), .secBeat(secBeat), .maskBeat(maskBeat),
    .sadAcc(sadTotal)
  );
endmodule

// File: rtl/blend_sad_chk.sv
module blend_sad_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             beatReady,
  input logic             busy,
  input logic             donePulse,
  input logic [ACC_W-1:0] sadTotal
);
  a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startPulse |=> busy);
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startPulse |=> sadTotal == '0);
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && startPulse |=> sadTotal >= $past(sadTotal));
  a_r3_no_shrink: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> sadTotal >= $past(sadTotal));
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !beatReady && !startPulse |=> $stable(sadTotal));
endmodule

bind blend_sad_engine blend_sad_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .beatReady(beatReady),
  .busy(busy), .donePulse(donePulse), .sadTotal(sadTotal)
);

// File: tb/blend_sad_engine_test.sv
`timescale 1ns/1ps
module blend_sad_engine_test;
  localparam int SW = 8;
  localparam int LN = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic startPulse = 1'b0, invertSel = 1'b0, beatValid = 1'b0;
  logic [2:0] widthCode = '0;
  logic [7:0] heightRows = '0;
  logic [LN*SW-1:0] srcBeat = '0, refBeat = '0, secBeat = '0;
  logic [LN*8-1:0]  maskBeat = '0;
  logic beatReady, busy, donePulse;
  logic [31:0] sadTotal;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  blend_sad_engine uut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference
  int mBusy = 0, mDone = 0, mLeft = 0, mW = 0, mInv = 0;
  longint mAcc = 0;

  function automatic int activeLanes(int wc);
    return ((4 << wc) > LN) ? LN : (4 << wc);
  endfunction
  function automatic int beatsPerRow(int wc);
    return (wc <= 1) ? 1 : (1 << (wc - 1));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mAcc = 0; mLeft = 0;
    end else begin
      mDone = 0;
      if (!mBusy && startPulse) begin
        mBusy = 1; mAcc = 0; mW = widthCode; mInv = invertSel;
        mLeft = heightRows * beatsPerRow(widthCode);
      end else if (mBusy && beatValid) begin
        for (int k = 0; k < activeLanes(mW); k++) begin
          int m, a, b, s, p;
          m = maskBeat[k*8 +: 8];
          a = mInv ? secBeat[k*SW +: SW] : refBeat[k*SW +: SW];
          b = mInv ? refBeat[k*SW +: SW] : secBeat[k*SW +: SW];
          s = srcBeat[k*SW +: SW];
          p = (m * a + (64 - m) * b + 32) / 64;
          mAcc += (p > s) ? p - s : s - p;
        end
        mLeft--;
        if (mLeft == 0) begin mBusy = 0; mDone = 1; end
      end
    end
  end

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // every-cycle comparison and watchdog
  always @(negedge clk) begin
    if (rstN) begin
      check("R4/R7 busy", busy, mBusy);
      check("R8 ready", beatReady, mBusy);
      check("R9 done", donePulse, mDone);
      check("R3 sum", sadTotal, mAcc);
    end
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish();
    end
  end

  task automatic fillBeat(int wc, bit rnd, int cm, int cr, int cs, int csrc);
    for (int k = 0; k < LN; k++) begin
      if (k >= activeLanes(wc)) begin       // R6 garbage on unused lanes
        maskBeat[k*8 +: 8] = 8'd17; refBeat[k*SW +: SW] = 8'd255;
        secBeat[k*SW +: SW] = 8'd255; srcBeat[k*SW +: SW] = 8'd0;
      end else if (rnd) begin
        maskBeat[k*8 +: 8] = 8'($urandom_range(0, 64));
        refBeat[k*SW +: SW] = 8'($urandom); secBeat[k*SW +: SW] = 8'($urandom);
        srcBeat[k*SW +: SW] = 8'($urandom);
      end else begin
        maskBeat[k*8 +: 8] = 8'(cm); refBeat[k*SW +: SW] = 8'(cr);
        secBeat[k*SW +: SW] = 8'(cs); srcBeat[k*SW +: SW] = 8'(csrc);
      end
    end
  endtask

  task automatic runBlock(string tag, int wc, int h, bit inv, bit rnd,
                          int cm, int cr, int cs, int csrc, int gap,
                          bit midStart, longint expSad);
    int beats;
    beats = h * beatsPerRow(wc);
    startPulse = 1; widthCode = 3'(wc); heightRows = 8'(h); invertSel = inv;
    @(negedge clk);
    startPulse = 0;
    check("R4 start clears", sadTotal, 0);
    check("R4 start busy", busy, 1);
    for (int i = 0; i < beats; i++) begin
      if (gap != 0 && (i % gap) == 1) begin
        beatValid = 0; fillBeat(wc, 1, 0, 0, 0, 0);   // R8 ignored data
        @(negedge clk);
      end
      fillBeat(wc, rnd, cm, cr, cs, csrc);
      beatValid = 1;
      if (midStart && i == 2) begin                   // R5
        startPulse = 1; widthCode = 3'd5; heightRows = 8'd2; invertSel = !inv;
      end
      @(negedge clk);
      startPulse = 0;
    end
    beatValid = 0;
    for (int g = 0; g < 40 && !donePulse; g++) @(negedge clk);
    check({tag, " done"}, donePulse, 1);
    check("R7 busy low at done", busy, 0);
    if (expSad >= 0) check(tag, sadTotal, expSad);
    @(negedge clk);
    check("R9 result held", sadTotal, mAcc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R4 reset busy", busy, 0);
    check("R4 reset sum", sadTotal, 0);
    check("R4 reset done", donePulse, 0);

    runBlock("R1 half rounds up", 0, 4, 0, 0, 32, 1, 0, 0, 0, 0, 16);
    runBlock("R1 below half", 0, 4, 0, 0, 31, 1, 0, 0, 0, 0, 0);
    runBlock("R10 mask zero", 0, 4, 0, 0, 0, 200, 10, 0, 0, 0, 160);
    runBlock("R10 mask full", 0, 4, 0, 0, 64, 200, 10, 0, 0, 0, 3200);
    runBlock("R2 invert full", 0, 4, 1, 0, 64, 200, 10, 0, 0, 0, 160);
    runBlock("R2 invert zero", 0, 4, 1, 0, 0, 200, 10, 0, 0, 0, 3200);
    runBlock("R6 narrow lanes", 0, 4, 0, 0, 32, 100, 20, 50, 0, 0, 160);
    runBlock("R7 8x32", 1, 32, 0, 0, 64, 3, 0, 0, 0, 0, 768);
    runBlock("R5 restart ignored", 2, 8, 0, 0, 64, 5, 0, 0, 0, 1, 640);
    runBlock("R8 gaps 32x8", 3, 8, 0, 1, 0, 0, 0, 0, 3, 0, -1);
    runBlock("R3 16x4 inv", 2, 4, 1, 1, 0, 0, 0, 0, 0, 0, -1);
    runBlock("R3 4x16", 0, 16, 0, 1, 0, 0, 0, 0, 2, 0, -1);
    runBlock("R3 64x16", 4, 16, 1, 1, 0, 0, 0, 0, 5, 0, -1);
    runBlock("R3 128x128", 5, 128, 0, 1, 0, 0, 0, 0, 0, 0, -1);
    runBlock("R7 128 wide max", 5, 1, 0, 0, 64, 255, 0, 0, 0, 0, 128 * 255);

    repeat (3) @(negedge clk);
    check("R9 idle hold", sadTotal, 128 * 255);
    finish();
  end
endmodule